// File: doc/BRIEF.md
# Serial Transmitter with Byte Queue

This block turns bytes written by a host into asynchronous serial frames on a single output line. Bytes go into a queue of up to 64 entries. When the queue mode is switched off, the queue keeps only one byte. A shift stage takes the oldest byte and sends a frame. The frame has a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then high stop bits. When no frame is being sent, the line rests high.

Each bit lasts a fixed number of pulses on the `tick` enable input: 16, 8 or 4 pulses, as selected. The frame format is captured when a byte is taken from the queue, so a setting changed in the middle of a frame applies only from the next frame. When a frame ends and another byte is waiting, the next start bit begins in the very next cycle. Two flags report the state of the block. The first shows that the queue is empty. The second shows that the queue is empty and the line is also idle.

Top module: `sertx_top`

## Requirements
- R1: After synchronous reset, `txd` is 1, `hold_empty` is 1 and `tx_empty` is 1.
- R2: With `fifo_en`=1, the queue accepts up to 64 bytes. A write made while the queue holds 64 bytes is dropped, and bytes are sent in the order they were written.
- R3: With `fifo_en`=0, only one byte can wait. A write made while that byte is still waiting is dropped.
- R4: A frame is one low start bit, then the data bits with bit 0 first, then an optional parity bit, then stop bits that are high. Between frames the line stays high.
- R5: `wlen` sets the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Data bits above the word length are not sent.
- R6: With `par_en`=1, a parity bit follows the data. With `par_odd`=0 the count of ones in data plus parity is even. With `par_odd`=1 that count is odd.
- R7: With `stop2`=0 there is one stop bit. With `stop2`=1 there are two, except when `wlen`=0: then the second stop bit lasts half a bit time.
- R8: A bit lasts 16 `tick` pulses when `osr`=0 or 3, 8 pulses when `osr`=1, and 4 pulses when `osr`=2. The start bit begins in the cycle after the byte is taken, and its count of ticks starts there.
- R9: When a frame's last stop bit ends and a byte is waiting, the next start bit begins in the next cycle, with no idle gap. A byte written to an idle, empty block is taken in the next cycle.
- R10: `hold_empty` is 1 exactly when no byte is waiting. `tx_empty` is 1 exactly when no byte is waiting and no frame is being sent.
- R11: A cycle with `fifo_clr`=1 drops all waiting bytes and any write made in that cycle. A frame already being sent continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Sampling tick enable |
| wr_en | input | 1 | Write strobe for `wr_data` |
| wr_data | input | 8 | Byte to be sent |
| fifo_en | input | 1 | 1: 64-entry queue, 0: single holding byte |
| fifo_clr | input | 1 | Pulse that empties the queue |
| wlen | input | 2 | Word length code (5 + value) |
| par_en | input | 1 | Parity bit enable |
| par_odd | input | 1 | 1: odd parity, 0: even parity |
| stop2 | input | 1 | Second stop bit (half a bit when `wlen`=0) |
| osr | input | 2 | Ticks per bit: 0 or 3 gives 16, 1 gives 8, 2 gives 4 |
| txd | output | 1 | Serial line |
| hold_empty | output | 1 | Queue empty |
| tx_empty | output | 1 | Queue empty and line idle |

## Verification
Some properties are checked by assertions on every cycle. The queue count never goes past its depth, a write to a full queue leaves the count unchanged, and a clear leaves the queue empty. Every byte taken from the queue starts with a low bit, the last bit of a frame is high, the tick counter stays below the bit length, and the line is high whenever the block reports it is fully empty. Other behaviour can be shown only by the bench scenarios, which compare the line and both flags against a behavioural model on every clock. These are the exact bit order and length for each word length, parity and stop setting, the three bit-time modes, frames sent with no gap, writes dropped in both queue modes, and a clear that leaves a running frame intact.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int DATA_W  = 8;
    localparam int FRAME_W = DATA_W + 4;
    localparam int IDX_W   = $clog2(FRAME_W);
    localparam int TICK_W  = 5;

    typedef enum logic [1:0] {
        OSR_16  = 2'd0,
        OSR_8   = 2'd1,
        OSR_4   = 2'd2,
        OSR_ALT = 2'd3
    } osr_e;

    typedef struct packed {
        logic [1:0] wlen;
        logic       par_en;
        logic       par_odd;
        logic       stop2;
        osr_e       osr;
    } line_cfg_t;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;
        logic [IDX_W-1:0]   last;
        logic               half;
        logic [TICK_W-1:0]  tpb;
    } frame_t;

    function automatic logic [TICK_W-1:0] ticks_per_bit(osr_e o);
        case (o)
            OSR_8:   return TICK_W'(8);
            OSR_4:   return TICK_W'(4);
            default: return TICK_W'(16);
        endcase
    endfunction

    function automatic frame_t build_frame(logic [DATA_W-1:0] d, line_cfg_t c);
        frame_t f;
        int     nd;
        int     pos;
        logic   p;
        nd     = 5 + int'(c.wlen);
        f.bits = '1;
        f.bits[0] = 1'b0;
        p = c.par_odd;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < nd) begin
                f.bits[1+i] = d[i];
                p = p ^ d[i];
            end
        end
        pos = 1 + nd;
        if (c.par_en) begin
            f.bits[pos] = p;
            pos = pos + 1;
        end
        if (c.stop2) pos = pos + 1;
        f.last = IDX_W'(pos);
        f.half = c.stop2 && (c.wlen == 2'd0);
        f.tpb  = ticks_per_bit(c.osr);
        return f;
    endfunction

endpackage

// File: rtl/sertx_fifo.sv
module sertx_fifo
    import sertx_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fifo_en,
    input  logic              clr,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic              empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wptr, rptr;
    logic [CW-1:0]     count;
    logic              full, do_push, do_pop;

    function automatic logic [AW-1:0] nxt(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = fifo_en ? (count >= CW'(DEPTH)) : (count != '0);
    assign empty   = (count == '0);
    assign do_push = push && !full && !clr;
    assign do_pop  = pop && !empty && !clr;
    assign head    = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= nxt(wptr);
            if (do_pop)  rptr <= nxt(rptr);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    a_r2_full_ignored: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop && !clr) |=> $stable(count));

    a_r11_clear_empties: assert property (@(posedge clk) disable iff (rst)
        clr |=> empty);
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              avail,
    input  logic [DATA_W-1:0] din,
    input  line_cfg_t         cfg,
    output logic              pop,
    output logic              busy,
    output logic              txd
);
    frame_t            fr;
    logic [IDX_W-1:0]  idx;
    logic [TICK_W-1:0] cnt;
    logic [TICK_W-1:0] cur_len;
    logic              bit_done, frame_end;

    assign cur_len   = (idx == fr.last && fr.half) ? (fr.tpb >> 1) : fr.tpb;
    assign bit_done  = busy && tick && (cnt == cur_len - 1'b1);
    assign frame_end = bit_done && (idx == fr.last);
    assign pop       = (!busy || frame_end) && avail;
    assign txd       = busy ? fr.bits[idx] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            fr   <= '0;
            idx  <= '0;
            cnt  <= '0;
        end else if (pop) begin
            busy <= 1'b1;
            fr   <= build_frame(din, cfg);
            idx  <= '0;
            cnt  <= '0;
        end else if (frame_end) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (busy && tick) begin
            if (bit_done) begin
                cnt <= '0;
                idx <= idx + 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    a_r4_start_after_load: assert property (@(posedge clk) disable iff (rst)
        pop |=> (busy && !txd));

    a_r4_last_bit_high: assert property (@(posedge clk) disable iff (rst)
        (busy && idx == fr.last) |-> txd);

    a_r8_count_in_range: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt < fr.tpb));
endmodule

// File: rtl/sertx_top.sv
module sertx_top
    import sertx_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    input  logic        wr_en,
    input  logic [7:0]  wr_data,
    input  logic        fifo_en,
    input  logic        fifo_clr,
    input  logic [1:0]  wlen,
    input  logic        par_en,
    input  logic        par_odd,
    input  logic        stop2,
    input  logic [1:0]  osr,
    output logic        txd,
    output logic        hold_empty,
    output logic        tx_empty
);
    line_cfg_t         cfg;
    logic [DATA_W-1:0] head;
    logic              empty, pop, busy;

    assign cfg = '{wlen: wlen, par_en: par_en, par_odd: par_odd,
                   stop2: stop2, osr: osr_e'(osr)};

    sertx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .fifo_en(fifo_en), .clr(fifo_clr),
        .push(wr_en), .push_data(wr_data), .pop(pop),
        .head(head), .empty(empty)
    );

    sertx_shifter u_shift (
        .clk(clk), .rst(rst), .tick(tick), .avail(!empty && !fifo_clr),
        .din(head), .cfg(cfg), .pop(pop), .busy(busy), .txd(txd)
    );

    assign hold_empty = empty;
    assign tx_empty   = empty && !busy;

    a_r10_idle_line_high: assert property (@(posedge clk) disable iff (rst)
        tx_empty |-> txd);
endmodule

// File: tb/tb_sertx_top.sv
module tb_sertx_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       fifo_en = 1'b1;
    logic       fifo_clr = 1'b0;
    logic [1:0] wlen = 2'd3;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       stop2 = 1'b0;
    logic [1:0] osr = 2'd0;
    logic       txd, hold_empty, tx_empty;

    sertx_top dut (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_data(wr_data),
        .fifo_en(fifo_en), .fifo_clr(fifo_clr), .wlen(wlen), .par_en(par_en),
        .par_odd(par_odd), .stop2(stop2), .osr(osr),
        .txd(txd), .hold_empty(hold_empty), .tx_empty(tx_empty)
    );

    always #4 clk = ~clk;

    int    n_checks = 0;
    int    n_fails  = 0;
    int    cyc      = 0;
    string cur_req  = "R1";
    bit    cmp_on   = 1'b0;
    bit    done     = 1'b0;

    // reference model state
    byte unsigned q[$];
    bit  m_busy = 0;
    int  m_bits[12];
    int  m_idx = 0, m_last = 0, m_cnt = 0, m_T = 16;
    bit  m_half = 0;

    task automatic check(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s actual %0d expected %0d (time %0t)", req, what, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        int cap, len, nd, ones, pos;
        bit acc, end_f, ready;
        byte unsigned b;
        if (rst) begin
            q.delete();
            m_busy = 0; m_idx = 0; m_cnt = 0;
        end else begin
            cap = fifo_en ? 64 : 1;
            acc = wr_en && (q.size() < cap);
            end_f = 0;
            if (m_busy && tick) begin
                len = (m_idx == m_last && m_half) ? m_T / 2 : m_T;
                if (m_cnt == len - 1) begin
                    m_cnt = 0;
                    if (m_idx == m_last) end_f = 1; else m_idx++;
                end else m_cnt++;
            end
            ready = !m_busy || end_f;
            if (ready && q.size() > 0 && !fifo_clr) begin
                b = q.pop_front();
                nd = 5 + wlen;
                m_bits[0] = 0;
                ones = 0;
                for (int i = 0; i < nd; i++) begin
                    m_bits[1+i] = (b >> i) & 1;
                    ones += m_bits[1+i];
                end
                pos = 1 + nd;
                if (par_en) begin
                    m_bits[pos] = par_odd ? ((ones % 2) == 0) : (ones % 2);
                    pos++;
                end
                m_bits[pos] = 1;
                if (stop2) begin pos++; m_bits[pos] = 1; end
                m_last = pos;
                m_half = stop2 && (nd == 5);
                m_T = (osr == 2'd1) ? 8 : (osr == 2'd2) ? 4 : 16;
                m_idx = 0; m_cnt = 0; m_busy = 1;
            end else if (end_f) begin
                m_busy = 0;
            end
            if (fifo_clr) q.delete();
            else if (acc) q.push_back(wr_data);
        end
    end

    always @(negedge clk) begin
        if (cmp_on && !done) begin
            check(cur_req, "txd", int'(txd), m_busy ? m_bits[m_idx] : 1);
            check(cur_req, "hold_empty", int'(hold_empty), int'(q.size() == 0));
            check(cur_req, "tx_empty", int'(tx_empty), int'(q.size() == 0 && !m_busy));
        end
    end

    int tdiv = 0;
    always @(negedge clk) begin
        #1;
        tdiv = (tdiv == 1) ? 0 : tdiv + 1;
        tick = (tdiv == 1);
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_fails++;
            $display("FAIL watchdog %s actual %0d expected %0d cycles", cur_req, cyc, 150000);
            summary();
        end
    end

    task automatic put(byte unsigned b);
        @(negedge clk); #1;
        wr_en = 1'b1; wr_data = b;
    endtask

    task automatic quiet();
        @(negedge clk); #1;
        wr_en = 1'b0; fifo_clr = 1'b0;
    endtask

    task automatic set_cfg(int wl, bit pe, bit po, bit s2, int o);
        @(negedge clk); #1;
        wlen = 2'(wl); par_en = pe; par_odd = po; stop2 = s2; osr = 2'(o);
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 40000; k++) begin
            @(negedge clk);
            if (!m_busy && q.size() == 0) break;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic send1(byte unsigned b);
        put(b); quiet(); wait_idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1", "txd", int'(txd), 1);
        check("R1", "hold_empty", int'(hold_empty), 1);
        check("R1", "tx_empty", int'(tx_empty), 1);
        cmp_on = 1'b1;

        // R4, R8: 8 data bits, 16 ticks per bit
        cur_req = "R4";
        set_cfg(3, 0, 0, 0, 0);
        send1(8'hA5);
        send1(8'h3C);

        // R5: each word length, high bits dropped
        cur_req = "R5";
        for (int w = 0; w < 4; w++) begin
            set_cfg(w, 0, 0, 0, 1);
            send1(8'hFF);
            send1(8'h96);
        end

        // R6: even and odd parity
        cur_req = "R6";
        for (int w = 0; w < 4; w++) begin
            set_cfg(w, 1, 0, 0, 1);
            send1(8'h5B);
            set_cfg(w, 1, 1, 0, 1);
            send1(8'h5B);
            send1(8'h00);
        end

        // R7: two stop bits and 1.5 stop bits
        cur_req = "R7";
        set_cfg(3, 1, 1, 1, 2);
        send1(8'hC3);
        set_cfg(0, 0, 0, 1, 2);
        send1(8'h15);
        set_cfg(0, 1, 0, 1, 0);
        send1(8'h0A);

        // R8: every bit-time code
        cur_req = "R8";
        for (int o = 0; o < 4; o++) begin
            set_cfg(2, 0, 0, 0, o);
            send1(8'h6D);
        end

        // R9: back-to-back frames with no gap
        cur_req = "R9";
        set_cfg(3, 0, 0, 0, 2);
        put(8'h81); put(8'h7E); put(8'hF0); quiet();
        wait_idle();

        // R2: fill beyond 64 entries, extras dropped, order kept
        cur_req = "R2";
        set_cfg(3, 1, 0, 0, 2);
        for (int i = 0; i < 70; i++) put(8'(i * 7 + 1));
        quiet();
        wait_idle();

        // R3: single holding byte
        cur_req = "R3";
        @(negedge clk); #1 fifo_en = 1'b0;
        put(8'h11); put(8'h22); put(8'h33); put(8'h44); quiet();
        wait_idle();
        @(negedge clk); #1 fifo_en = 1'b1;

        // R10: flags during queued traffic
        cur_req = "R10";
        set_cfg(1, 0, 0, 0, 1);
        put(8'h2A); put(8'h15); quiet();
        wait_idle();

        // R11: clear while a frame is running, write in the same cycle dropped
        cur_req = "R11";
        set_cfg(3, 0, 0, 0, 2);
        put(8'hE7); put(8'h01); put(8'h02); put(8'h03); quiet();
        repeat (10) @(negedge clk);
        #1 fifo_clr = 1'b1; wr_en = 1'b1; wr_data = 8'h99;
        quiet();
        check("R11", "hold_empty after clear", int'(hold_empty), 1);
        check("R11", "line busy after clear", int'(tx_empty), 0);
        wait_idle();
        send1(8'h5A);

        summary();
    end
endmodule